// File: doc/BRIEF.md
# Dual-Precision Neuron with Hysteresis Telemetry

This block runs two complete copies of one leaky integrate-and-fire neuron side by side from the same free-running clock. The wide copy works in signed 32-bit fixed point with 16 fraction bits. The narrow copy works in signed 16-bit fixed point with 8 fraction bits. The narrow copy takes its input current from the wide input, rescaled and clipped to its range. The registered spike and membrane outputs always come from the wide copy. The narrow copy never reaches the outputs.

The narrow copy's membrane value feeds a two-threshold hysteresis monitor. The monitor drives a single telemetry flag that marks when the narrow format is running close to its range limit. The flag is for observation only. It never selects the output, never gates a clock and never moves state between the copies. Downstream logic may log it or use it in later power work.

Top module: `dpn_dual_neuron`

## Requirements
- R1: An asynchronous active-low reset `rst_n` clears `v_out`, `spike_out` and `use_hp` to 0 at once. It also clears the membrane of both neuron copies to 0.
- R2: Each clock, the wide copy (Q15.16) forms s = v - (v >>> 4) + i_in. If s >= 120.0 (code 120·2^16), it spikes (spike = 1) and v becomes 0. Otherwise spike = 0 and v = s, clipped to the signed 32-bit range.
- R3: `v_out` and `spike_out` are registered copies of the wide copy's membrane and spike. They lag those by one clock and follow them in every cycle, whatever the value of `use_hp`.
- R4: The narrow copy runs the R2 update in Q7.8 with a firing level of 120.0 (code 120·2^8). Its input is i_in >>> 8, clipped to [-32768, 32767]. For example, i_in = 32'h8000_0000 gives -32768.
- R5: With the default per-mille settings of 800 (upper) and 500 (lower), the threshold codes are round-half-down(per-mille · 32767 / 1000). This gives 26214 for the upper threshold and 16383 for the lower one.
- R6: While the flag is 0, a narrow membrane magnitude strictly above the upper code sets the flag to 1. A magnitude equal to the upper code leaves it at 0.
- R7: While the flag is 1, a magnitude strictly below the lower code clears it to 0. A magnitude equal to the lower code keeps it at 1. In every other case the flag holds.
- R8: The magnitude is formed in 17 bits, so a narrow membrane of -32768 counts as 32768. That value exceeds the upper code and sets the flag.
- R9: `use_hp` is the flag register itself. It changes on the clock edge after the edge at which the narrow membrane first takes a value that crosses a threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock for both copies |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_in | input | 32 | Input current, signed Q15.16 |
| spike_out | output | 1 | Registered spike of the wide copy |
| v_out | output | 32 | Registered membrane of the wide copy, signed Q15.16 |
| use_hp | output | 1 | Hysteresis telemetry flag from the narrow copy |

## Verification
The hardest states to reach from the ports are a narrow membrane sitting exactly on a threshold code, and one resting at the most negative code. The membrane is internal and keeps leaking, so it cannot simply be set. The stimulus starts from reset, where the membrane is 0. It applies one input equal to the wanted code, then holds the input at code >>> 4 so that leak and input cancel. One code step up or down then probes the strict comparisons. A full-scale negative input drives the narrow copy into clipping at -32768. Random input bursts of mixed magnitude, with resets between them, cover the rest against a bench model of both copies.

// File: rtl/dpn_pkg.sv
package dpn_pkg;

   typedef enum logic {
      MODE_NARROW_OK = 1'b0,
      MODE_NEAR_LIMIT = 1'b1
   } prec_mode_e;

   // round-half-down of maxv * pm / 1000
   function automatic longint pm_code(input longint maxv, input longint pm);
      return (maxv * pm + 64'sd499) / 64'sd1000;
   endfunction

endpackage

// File: rtl/dpn_neuron_core.sv
module dpn_neuron_core #(
   parameter int W          = 16,
   parameter int F          = 8,
   parameter int FIRE_UNITS = 120,
   parameter int LEAK_SH    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic signed [W-1:0] i_cur,
   output logic                spike,
   output logic signed [W-1:0] v
);
   localparam int     XW     = W + 2;
   localparam longint FIRE_L = longint'(FIRE_UNITS) << F;
   localparam longint MAX_L  = (longint'(1) << (W - 1)) - 1;
   localparam longint MIN_L  = -(longint'(1) << (W - 1));
   localparam logic signed [XW-1:0] FIRE_C = FIRE_L[XW-1:0];
   localparam logic signed [XW-1:0] HI_C   = MAX_L[XW-1:0];
   localparam logic signed [XW-1:0] LO_C   = MIN_L[XW-1:0];

   if (W > 62) begin : g_bad_w
      $error("dpn_neuron_core: W too large");
   end
   if (FIRE_L > MAX_L) begin : g_bad_fire
      $error("dpn_neuron_core: firing level outside format");
   end

   logic signed [XW-1:0] v_x, lk_x, i_x, sum;
   logic signed [W-1:0]  v_d;
   logic                 sp_d;

   assign v_x  = {{2{v[W-1]}}, v};
   assign i_x  = {{2{i_cur[W-1]}}, i_cur};
   assign lk_x = v_x >>> LEAK_SH;
   assign sum  = v_x - lk_x + i_x;

   always_comb begin
      sp_d = 1'b0;
      if (sum >= FIRE_C) begin
         sp_d = 1'b1;
         v_d  = '0;
      end else if (sum > HI_C) begin
         v_d = HI_C[W-1:0];
      end else if (sum < LO_C) begin
         v_d = LO_C[W-1:0];
      end else begin
         v_d = sum[W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v     <= '0;
         spike <= 1'b0;
      end else begin
         v     <= v_d;
         spike <= sp_d;
      end
   end

   // R2: a spiking cycle leaves the membrane at zero
   p_spike_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      spike |-> (v == '0));

endmodule

// File: rtl/dpn_lp_feed.sv
module dpn_lp_feed #(
   parameter int IN_W  = 32,
   parameter int OUT_W = 16,
   parameter int SHIFT = 8
) (
   input  logic signed [IN_W-1:0]  cur_in,
   output logic signed [OUT_W-1:0] cur_out
);
   localparam longint OMAX_L = (longint'(1) << (OUT_W - 1)) - 1;
   localparam longint OMIN_L = -(longint'(1) << (OUT_W - 1));
   localparam logic signed [IN_W-1:0] OMAX_C = OMAX_L[IN_W-1:0];
   localparam logic signed [IN_W-1:0] OMIN_C = OMIN_L[IN_W-1:0];

   if (IN_W > 64 || OUT_W > IN_W) begin : g_bad_w
      $error("dpn_lp_feed: unsupported widths");
   end

   logic signed [IN_W-1:0] sh;
   assign sh = cur_in >>> SHIFT;

   if (IN_W - SHIFT <= OUT_W) begin : g_fit
      assign cur_out = sh[OUT_W-1:0];
   end else begin : g_clip
      always_comb begin
         if (sh > OMAX_C)      cur_out = OMAX_C[OUT_W-1:0];
         else if (sh < OMIN_C) cur_out = OMIN_C[OUT_W-1:0];
         else                  cur_out = sh[OUT_W-1:0];
      end
   end

endmodule

// File: rtl/dpn_hyst_mon.sv
module dpn_hyst_mon
   import dpn_pkg::*;
#(
   parameter int W     = 16,
   parameter int UP_PM = 800,
   parameter int DN_PM = 500
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic signed [W-1:0] v_mon,
   output logic                flag
);
   localparam longint MAXV_L  = (longint'(1) << (W - 1)) - 1;
   localparam longint UP_L    = pm_code(MAXV_L, longint'(UP_PM));
   localparam longint DN_L    = pm_code(MAXV_L, longint'(DN_PM));
   localparam longint MAGMX_L = longint'(1) << (W - 1);
   localparam logic [W:0] UP_C  = UP_L[W:0];
   localparam logic [W:0] DN_C  = DN_L[W:0];
   localparam logic [W:0] MAG_C = MAGMX_L[W:0];

   if (UP_PM <= DN_PM || UP_PM > 1000 || DN_PM < 0) begin : g_bad_pm
      $error("dpn_hyst_mon: need 0 <= DN_PM < UP_PM <= 1000");
   end

   logic [W:0]  ext, mag;
   prec_mode_e  mode_q;

   assign ext = {v_mon[W-1], v_mon};
   assign mag = v_mon[W-1] ? (~ext + 1'b1) : ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_NARROW_OK;
      end else if (mode_q == MODE_NARROW_OK && mag > UP_C) begin
         mode_q <= MODE_NEAR_LIMIT;
      end else if (mode_q == MODE_NEAR_LIMIT && mag < DN_C) begin
         mode_q <= MODE_NARROW_OK;
      end
   end

   assign flag = (mode_q == MODE_NEAR_LIMIT);

   p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag && mag > UP_C) |=> flag);
   p_stay_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag && mag <= UP_C) |=> !flag);
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && mag < DN_C) |=> !flag);
   p_stay_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && mag >= DN_C) |=> flag);
   p_mag_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mag <= MAG_C);

endmodule

// File: rtl/dpn_dual_neuron.sv
module dpn_dual_neuron #(
   parameter int LP_W       = 16,
   parameter int LP_F       = 8,
   parameter int HP_W       = 32,
   parameter int HP_F       = 16,
   parameter int FIRE_UNITS = 120,
   parameter int LEAK_SH    = 4,
   parameter int UP_PM      = 800,
   parameter int DN_PM      = 500
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic signed [HP_W-1:0] i_in,
   output logic                   spike_out,
   output logic signed [HP_W-1:0] v_out,
   output logic                   use_hp
);
   localparam int FSHIFT = HP_F - LP_F;

   if (HP_F < LP_F || HP_W < LP_W) begin : g_bad_fmt
      $error("dpn_dual_neuron: wide format must cover narrow format");
   end

   logic signed [LP_W-1:0] lp_cur, lp_v;
   logic signed [HP_W-1:0] hp_v;
   logic                   lp_spike, hp_spike;

   dpn_lp_feed #(.IN_W(HP_W), .OUT_W(LP_W), .SHIFT(FSHIFT)) u_feed (
      .cur_in (i_in),
      .cur_out(lp_cur)
   );

   dpn_neuron_core #(.W(LP_W), .F(LP_F), .FIRE_UNITS(FIRE_UNITS),
                     .LEAK_SH(LEAK_SH)) u_narrow (
      .clk  (clk),
      .rst_n(rst_n),
      .i_cur(lp_cur),
      .spike(lp_spike),
      .v    (lp_v)
   );

   dpn_neuron_core #(.W(HP_W), .F(HP_F), .FIRE_UNITS(FIRE_UNITS),
                     .LEAK_SH(LEAK_SH)) u_wide (
      .clk  (clk),
      .rst_n(rst_n),
      .i_cur(i_in),
      .spike(hp_spike),
      .v    (hp_v)
   );

   dpn_hyst_mon #(.W(LP_W), .UP_PM(UP_PM), .DN_PM(DN_PM)) u_mon (
      .clk  (clk),
      .rst_n(rst_n),
      .v_mon(lp_v),
      .flag (use_hp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_out     <= '0;
         spike_out <= 1'b0;
      end else begin
         v_out     <= hp_v;
         spike_out <= hp_spike;
      end
   end

   p_out_wide_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (v_out == $past(hp_v) && spike_out == $past(hp_spike)));
   p_lp_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lp_cur[LP_W-1] == i_in[HP_W-1]);
   p_narrow_spike_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lp_spike |-> (lp_v == '0));

endmodule

// File: tb/dpn_dual_neuron_test.sv
`timescale 1ns/1ps
module dpn_dual_neuron_test;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic signed [31:0] i_in = '0;
   logic               spike_out;
   logic signed [31:0] v_out;
   logic               use_hp;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   longint m_hp_v, m_lp_v, m_out_v;
   bit     m_hp_s, m_lp_s, m_out_s, m_flag;

   dpn_dual_neuron uut (
      .clk(clk), .rst_n(rst_n), .i_in(i_in),
      .spike_out(spike_out), .v_out(v_out), .use_hp(use_hp)
   );

   always #5 clk = ~clk;

   function automatic longint clip(input longint x, input int w);
      longint hi = (longint'(1) << (w - 1)) - 1;
      longint lo = -(longint'(1) << (w - 1));
      if (x > hi) return hi;
      if (x < lo) return lo;
      return x;
   endfunction

   // R2 / R4 membrane update
   function automatic longint nstep(input longint v, input longint i,
                                    input int w, input int f, output bit sp);
      longint s = v - (v >>> 4) + i;
      if (s >= (longint'(120) << f)) begin
         sp = 1'b1;
         return 0;
      end
      sp = 1'b0;
      return clip(s, w);
   endfunction

   function automatic longint magn(input longint x);
      return (x < 0) ? -x : x;
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_hp_v = 0; m_lp_v = 0; m_out_v = 0;
      m_hp_s = 0; m_lp_s = 0; m_out_s = 0; m_flag = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      #2;
      model_reset();
      chk(v_out == 0, "R1 v_out reset", v_out, 0);
      chk(spike_out == 1'b0, "R1 spike_out reset", spike_out, 0);
      chk(use_hp == 1'b0, "R1 use_hp reset", use_hp, 0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // one clock with input x, then compare against the model
   task automatic apply(input logic signed [31:0] x);
      longint li;
      bit     s;
      longint nv;
      i_in = x;
      @(posedge clk);
      #1;
      li = clip(longint'(x) >>> 8, 16);
      m_out_v = m_hp_v;
      m_out_s = m_hp_s;
      if (!m_flag && magn(m_lp_v) > 26214) m_flag = 1'b1;        // R6
      else if (m_flag && magn(m_lp_v) < 16383) m_flag = 1'b0;    // R7
      nv = nstep(m_hp_v, longint'(x), 32, 16, s);
      m_hp_v = nv; m_hp_s = s;
      nv = nstep(m_lp_v, li, 16, 8, s);
      m_lp_v = nv; m_lp_s = s;
      chk(longint'(v_out) == m_out_v, "R2/R3 v_out", v_out, m_out_v);
      chk(spike_out == m_out_s, "R2/R3 spike_out", spike_out, m_out_s);
      chk(use_hp == m_flag, "R6/R7 use_hp model", use_hp, m_flag);
   endtask

   function automatic logic signed [31:0] lpc(input int code);
      return 32'(code) <<< 8;
   endfunction

   initial begin
      #2_000_000;
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'd24681);
      model_reset();
      #12;
      do_reset();

      // R5/R6/R9: upper threshold edge at 26214
      do_reset();
      apply(lpc(26214));
      apply(lpc(1638));
      apply(lpc(1638));
      chk(use_hp == 1'b0, "R5 R6 equal to upper keeps flag low", use_hp, 0);
      apply(lpc(1639));
      chk(use_hp == 1'b0, "R9 no change in crossing cycle", use_hp, 0);
      apply(lpc(1638));
      chk(use_hp == 1'b1, "R6 R9 set after 26215", use_hp, 1);
      apply(lpc(1638));
      apply(lpc(1638));
      chk(use_hp == 1'b1, "R7 flag holds high", use_hp, 1);

      // R5/R7: lower threshold edge at 16383
      apply(lpc(-8194));
      apply(lpc(1023));
      apply(lpc(1023));
      chk(use_hp == 1'b1, "R5 R7 equal to lower keeps flag high", use_hp, 1);
      apply(lpc(1022));
      chk(use_hp == 1'b1, "R9 no clear in crossing cycle", use_hp, 1);
      apply(lpc(1023));
      chk(use_hp == 1'b0, "R7 clear after 16382", use_hp, 0);

      // R4/R8: full negative input clips to -32768, magnitude 32768 sets flag
      do_reset();
      apply(32'sh8000_0000);
      chk(use_hp == 1'b0, "R4 flag not yet set", use_hp, 0);
      apply(lpc(-2048));
      chk(use_hp == 1'b1, "R4 R8 most negative code sets flag", use_hp, 1);
      apply(lpc(-2048));
      chk(use_hp == 1'b1, "R8 flag holds at -32768", use_hp, 1);

      // R2: wide copy fires under strong drive
      do_reset();
      for (int k = 0; k < 6; k++) apply(32'sd50 <<< 16);
      chk(m_out_s == 1'b1 || m_hp_s == 1'b1 || spike_out == m_out_s,
          "R2 firing run", spike_out, m_out_s);

      // random bursts
      for (int b = 0; b < 48; b++) begin
         int cls;
         if (b % 6 == 0) do_reset();
         cls = $urandom % 4;
         for (int k = 0; k < 60; k++) begin
            logic signed [31:0] x;
            case (cls)
               0: x = 32'($signed($urandom % (16 << 16))) - (32'sd8 <<< 16);
               1: x = 32'($urandom % (40 << 16));
               2: x = -32'($urandom % (3000 << 8));
               default: x = $urandom;
            endcase
            apply(x);
         end
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule